// File: doc/BRIEF.md
# Mode-Configurable GPIO Port with Pin-Change Interrupt

The block is an 8-pin general-purpose I/O port behind a small register bus with an address, write data, read data, a write strobe and a read strobe. Three registers live on the bus: pin data at offset 0x0, direction at offset 0x1 and option at offset 0x2. Each pin has its own pad connection: a sampled input level, an output value, an output enable and a pull-up enable.

The direction bit and the option bit of a pin together choose its mode. An input pin is floating when its option bit is clear. When its option bit is set, the pull-up is turned on and falling edges request an interrupt. An output pin is open-drain when its option bit is clear: it pulls low for data 0 and lets go for data 1. When its option bit is set, the output is push-pull. Pin 3 has no pull-up interrupt mode, so its option bit does nothing while it is an input.

Every pad input passes through a two-flop synchronizer. A single sticky interrupt flag serves the whole port. A read of the data register clears it. The edge history always follows the synchronized level, so a configuration write alone can never raise the flag.

Top module: `gpio_modeport`

## Requirements
- R1: After reset the data register holds 0x00, the direction register holds 0x08 and the option register holds 0x02, and the interrupt flag is low.
- R2: Writes to offsets 0x0, 0x1 and 0x2 update the data, direction and option registers. A write to offset 0x3 changes nothing, and a read of offset 0x3 returns 0x00.
- R3: An input pin (direction 0) never has its output enable asserted. With option 0 it has neither pull-up nor interrupt.
- R4: An input pin with option 1 asserts its pull-up enable, and a falling edge of its synchronized level sets the interrupt flag.
- R5: An output pin with option 0 is open-drain. Output enable is high and output is low when its data bit is 0, and output enable is low when its data bit is 1.
- R6: An output pin with option 1 is push-pull. Output enable is high and the output equals the data bit.
- R7: Pin 3 never asserts its pull-up enable and never sets the interrupt flag, whatever its option bit.
- R8: Reading offset 0x0 returns the synchronized pad level for input pins and the stored data bit for output pins.
- R9: The interrupt flag stays set until a read of offset 0x0 clears it. If a new edge arrives in the same cycle as that read, the flag stays set.
- R10: A configuration write never sets the interrupt flag on its own. This includes entering the interrupt mode while the pin is already low.
- R11: A pad input change reaches readback and edge detection only after the two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (a read of offset 0 clears the interrupt) |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| irq | output | 1 | Sticky port interrupt request |

## Verification
The bench builds the block with its default parameters: eight pins, pin 3 as the only pin without pull-up interrupt, and the stated reset values of direction and option. With these values the bench can test the reset pad state that the reset values produce, in which pin 3 is an open-drain output driving low and pin 1 is a pull-up interrupt input. It can also test that pin 3 stays masked after its option bit is set. One configuration covers all four modes on different pins at the same time, so the pad outputs and the mixed readback are checked together. The timing of the synchronizer and the history stage is also fixed, which lets the bench line up an edge with a clearing read in the same cycle.

// File: rtl/gpio_modeport.sv
module gpio_modeport #(
  parameter int          WIDTH     = 8,
  parameter int          ADDR_W    = 2,
  parameter logic [WIDTH-1:0] DIR_RST   = 8'h08,
  parameter logic [WIDTH-1:0] OPT_RST   = 8'h02,
  parameter logic [WIDTH-1:0] NOPU_MASK = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pu,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(2);

  logic [WIDTH-1:0] data_q, dir_q, opt_q;
  logic [WIDTH-1:0] s1_q, s2_q, hist_q;
  logic [WIDTH-1:0] int_en, fall;
  logic             irq_q, data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= DIR_RST;
      opt_q  <= OPT_RST;
    end else if (bus_we) begin
      if (bus_addr == A_DATA) data_q <= bus_wdata;
      if (bus_addr == A_DIR)  dir_q  <= bus_wdata;
      if (bus_addr == A_OPT)  opt_q  <= bus_wdata;
    end
  end

  // history tracks the synchronized level every cycle, including mode writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      hist_q <= '0;
    end else begin
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      hist_q <= s2_q;
    end
  end

  assign int_en  = ~dir_q & opt_q & ~NOPU_MASK;
  assign fall    = int_en & hist_q & ~s2_q;
  assign data_rd = bus_re && (bus_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (|fall)   irq_q <= 1'b1;
    else if (data_rd) irq_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = (dir_q & data_q) | (~dir_q & s2_q);
      A_DIR:   bus_rdata = dir_q;
      A_OPT:   bus_rdata = opt_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_oe  = dir_q & (opt_q | ~data_q);
  assign pad_out = dir_q & opt_q & data_q;
  assign pad_pu  = int_en;
  assign irq     = irq_q;
endmodule

// File: rtl/gpio_modeport_chk.sv
module gpio_modeport_chk #(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 2,
  parameter logic [WIDTH-1:0] NOPU_MASK = 8'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_re,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  opt_q,
  input logic [WIDTH-1:0]  fall,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_pu,
  input logic              irq
);
  // R3
  input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~dir_q & pad_oe) == '0);
  // R5
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & ~opt_q) == '0);
  // R7
  masked_pin_pu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & NOPU_MASK) == '0);
  // R4
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall) |=> irq);
  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == '0 && !(|fall)) |=> !irq);
  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(|fall)) |=> !irq);
endmodule

bind gpio_modeport gpio_modeport_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .NOPU_MASK(NOPU_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_re(bus_re),
  .dir_q(dir_q), .opt_q(opt_q), .fall(fall), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq)
);

// File: tb/gpio_modeport_bench.sv
module gpio_modeport_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 8'hFF;
  logic [7:0] pad_out, pad_oe, pad_pu;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  gpio_modeport u_gpio_modeport (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .irq(irq)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares every read against the scoreboard head
  always @(negedge clk) begin
    #2;
    if (bus_re) begin
      if (exp_q.size() == 0) check(bus_rdata, 8'hxx, "scoreboard empty");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sample;
    @(negedge clk);
    #1;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    sample;
    // R1 reset state: pin3 open-drain low, pin1 pull-up interrupt input
    check({7'd0, irq}, 8'h00, "R1 irq after reset");
    check(pad_oe, 8'h08, "R1/R5 reset pad_oe");
    check(pad_pu, 8'h02, "R1/R4 reset pad_pu");
    rd(2'd1, 8'h08, "R1 direction reset");
    rd(2'd2, 8'h02, "R1 option reset");
    rd(2'd0, 8'hF7, "R1/R8 data readback after reset");

    // R2 configure all modes: pins 0-3 inputs, 4-5 push-pull, 6-7 open-drain
    wr(2'd1, 8'hF0);
    wr(2'd2, 8'h3F);
    wr(2'd0, 8'h5A);
    sample;
    check(pad_pu, 8'h07, "R4/R7 pull-ups, pin3 masked");
    check(pad_oe, 8'hB0, "R3/R5/R6 output enables");
    check(pad_out, 8'h10, "R5/R6 output values");
    check({7'd0, irq}, 8'h00, "R10 configuration writes raise nothing");
    rd(2'd0, 8'h5F, "R8 mixed readback");
    rd(2'd1, 8'hF0, "R2 direction written");

    // R2 write to offset 3 ignored
    wr(2'd3, 8'hFF);
    rd(2'd3, 8'h00, "R2 offset 3 reads zero");
    rd(2'd2, 8'h3F, "R2 option unchanged by offset 3 write");

    // R11 synchronizer latency, R4 falling edge on pin0
    @(negedge clk);
    pad_in = 8'hFE;
    @(negedge clk); #1;
    check({7'd0, irq}, 8'h00, "R11 no irq after one stage");
    idle(3);
    sample;
    check({7'd0, irq}, 8'h01, "R4 falling edge sets irq");
    rd(2'd0, 8'h5E, "R8/R11 synchronized pin0 low");
    sample;
    check({7'd0, irq}, 8'h00, "R9 data read clears irq");

    // R7 pin3 falling edge ignored
    @(negedge clk);
    pad_in = 8'hF6;
    idle(5);
    sample;
    check({7'd0, irq}, 8'h00, "R7 pin3 edge ignored");

    // R3 floating input pin0 ignores edges
    @(negedge clk);
    pad_in = 8'hFF;
    wr(2'd2, 8'h3E);
    idle(4);
    @(negedge clk);
    pad_in = 8'hFE;
    idle(5);
    sample;
    check({7'd0, irq}, 8'h00, "R3 floating input has no interrupt");
    check(pad_pu, 8'h06, "R3 floating input has no pull-up");

    // R9 edge in the same cycle as the clearing read keeps irq set
    @(negedge clk);
    pad_in = 8'hFC;                      // pin1 falls
    idle(5);
    sample;
    check({7'd0, irq}, 8'h01, "R4 pin1 edge sets irq");
    pad_in = 8'hF8;                      // pin2 falls, edge visible after two edges
    @(negedge clk);
    @(negedge clk);
    bus_addr = 2'd0; bus_re = 1'b1;      // clearing read aligned with the edge
    exp_q.push_back(8'h58); tag_q.push_back("R8 readback during collision");
    @(negedge clk);
    bus_re = 1'b0;
    #1;
    check({7'd0, irq}, 8'h01, "R9 new edge wins over clear");
    rd(2'd0, 8'h58, "R9 second read");
    sample;
    check({7'd0, irq}, 8'h00, "R9 second read clears");

    // R10 entering interrupt mode while already low
    @(negedge clk);
    pad_in = 8'hE8;                      // pin4 low while it is an output
    idle(4);
    wr(2'd1, 8'hE0);                     // pin4 becomes input, option bit already 1
    idle(5);
    sample;
    check(pad_pu, 8'h16, "R4 pin4 pull-up in interrupt mode");
    check({7'd0, irq}, 8'h00, "R10 no irq on entering mode at low level");

    idle(2);
    check(8'(exp_q.size()), 8'h00, "scoreboard drained");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule